// File: doc/BRIEF.md
# Audio Codec Mixer Control Register Bank

This block is the control register file of an audio codec's mixer. A host reaches it through a simple indexed port. The port has a 7-bit index, a 16-bit write word with a write strobe, and a read strobe that returns a registered 16-bit word. The bank stores the volume, mute and gain words for these channels:

- master output
- headphone output
- beep tone
- phone input
- microphone input
- line input
- CD input

It also holds one link-configuration word. Each stored word is reduced to the bits it implements. Index 00h does not store anything: a read returns a fixed identification word, and a write of any value is a soft reset.

Every volume word is decoded into per-channel control buses that the analog datapath consumes. Each bus carries a mute flag and an attenuation code. A set mute flag also forces the code to maximum attenuation, so downstream logic cannot let a signal through while muted. The beep control leaves reset unmuted at 0 dB, so the beep tone can still be heard while the rest of the codec is held in reset.

Top module: `ccr_bank`

## Requirements
- R1: A high `rst` sampled at a clock edge loads every register with its default, including 74h. The defaults are: 02h = 8000h, 04h = 8000h, 0Ah = 0000h, 0Ch = 8008h, 0Eh = 8008h, 10h = 8808h, 12h = 8808h, 74h = 0000h.
- R2: A write of any value to index 00h (or 01h) returns every register to its R1 default in one cycle, except 74h, which keeps its contents.
- R3: A read of index 00h returns `{1'b0, ENH_CODE[4:0], CAP_ID[9:0]}`: the enhancement code sits in bits 14:10 and the capability ID in bits 9:0. With the default parameters this word is 3440h.
- R4: An odd index reaches the same register as the even index one below it, for both reads and writes.
- R5: A write to an index that holds no register changes nothing, and a read of such an index returns 0000h.
- R6: Only the implemented bits are stored, and every other bit reads 0. The layout of each register is:
  - 02h and 04h: mute in bit 15, left code in 13:8, right code in 5:0.
  - 0Ah: mute in bit 15, level in 4:1.
  - 0Ch: mute in bit 15, code in 4:0.
  - 0Eh: mute in bit 15, boost in bit 6, code in 4:0.
  - 10h and 12h: mute in bit 15, left code in 12:8, right code in 4:0.
  - 74h: all 16 bits are stored.
- R7: Each volume output bus is `{mute, code}`. When mute is 0 the bus is `{0, stored code}`. When mute is 1 the bus is `{1, all ones}`, whatever code is stored. The bus reflects a write two clock edges after the write is sampled.
- R8: `out_mic_boost` follows bit 6 of register 0Eh.
- R9: While `rst` is high, `out_beep` holds 00h (unmuted, 0 dB) and the master buses hold 7Fh (muted).
- R10: A read strobe sampled at an edge raises `rd_valid` for exactly the following cycle. That read returns the register contents from before that edge, so a write sampled at the same edge is not yet visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_idx | input | 7 | Register index |
| host_wdata | input | 16 | Write word |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read word |
| rd_valid | output | 1 | Read word valid |
| out_mst_l | output | 7 | Master left {mute, code} |
| out_mst_r | output | 7 | Master right {mute, code} |
| out_hp_l | output | 7 | Headphone left {mute, code} |
| out_hp_r | output | 7 | Headphone right {mute, code} |
| out_beep | output | 5 | Beep {mute, level} |
| out_phone | output | 6 | Phone {mute, code} |
| out_mic | output | 6 | Microphone {mute, code} |
| out_mic_boost | output | 1 | Microphone 20 dB boost enable |
| out_line_l | output | 6 | Line-in left {mute, code} |
| out_line_r | output | 6 | Line-in right {mute, code} |
| out_cd_l | output | 6 | CD left {mute, code} |
| out_cd_r | output | 6 | CD right {mute, code} |
| out_link_cfg | output | 16 | Link configuration word (74h) |

## Verification
The bench builds the bank with its default identification parameters, CAP_ID = 040h and ENH_CODE = 0Dh. This makes the ID read a known constant, 3440h, that can be compared exactly. Because the index width is fixed at 7, the bench can reach an unimplemented index (06h), both odd aliases of real registers (01h, 03h, 0Fh) and the preserved word at 74h. This lets it exercise soft reset against a live link word, and a write and a read of the same register in one cycle.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 16;
  localparam int NSLOT  = 8;
  localparam int SLOT_W = $clog2(NSLOT);

  localparam int S_MST   = 0;
  localparam int S_HP    = 1;
  localparam int S_BEEP  = 2;
  localparam int S_PHONE = 3;
  localparam int S_MIC   = 4;
  localparam int S_LINE  = 5;
  localparam int S_CD    = 6;
  localparam int S_LINK  = 7;

  localparam int MUTE_BIT  = 15;
  localparam int BOOST_BIT = 6;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_sel_t;

  function automatic logic [IDX_W-1:0] slot_index(int s);
    case (s)
      S_MST:   return 7'h02;
      S_HP:    return 7'h04;
      S_BEEP:  return 7'h0A;
      S_PHONE: return 7'h0C;
      S_MIC:   return 7'h0E;
      S_LINE:  return 7'h10;
      S_CD:    return 7'h12;
      default: return 7'h74;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_default(int s);
    case (s)
      S_MST, S_HP:    return 16'h8000;
      S_BEEP:         return 16'h0000;
      S_PHONE, S_MIC: return 16'h8008;
      S_LINE, S_CD:   return 16'h8808;
      default:        return 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(int s);
    case (s)
      S_MST, S_HP:  return 16'hBF3F;
      S_BEEP:       return 16'h801E;
      S_PHONE:      return 16'h801F;
      S_MIC:        return 16'h805F;
      S_LINE, S_CD: return 16'h9F1F;
      default:      return 16'hFFFF;
    endcase
  endfunction
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output slot_sel_t        sel,
  output logic             is_id
);
  logic [NSLOT-1:0] match;

  for (genvar s = 0; s < NSLOT; s++) begin : g_match
    localparam logic [IDX_W-1:0] BASE = slot_index(s);
    assign match[s] = (idx[IDX_W-1:1] == BASE[IDX_W-1:1]);
  end

  always_comb begin
    sel = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (match[s]) begin
        sel.hit  = 1'b1;
        sel.slot = SLOT_W'(s);
      end
    end
  end

  assign is_id = (idx[IDX_W-1:1] == '0);
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter logic [9:0] CAP_ID   = 10'h040,
  parameter logic [4:0] ENH_CODE = 5'h0D
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic                          re,
  input  logic [DATA_W-1:0]             wdata,
  input  slot_sel_t                     sel,
  input  logic                          is_id,
  output logic [NSLOT-1:0][DATA_W-1:0]  words,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid
);
  localparam logic [DATA_W-1:0] ID_WORD = {1'b0, ENH_CODE, CAP_ID};

  logic soft_rst;
  assign soft_rst = we & is_id;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [DATA_W-1:0] DEF  = slot_default(s);
    localparam logic [DATA_W-1:0] MASK = slot_mask(s);
    logic wr_hit;
    assign wr_hit = we & sel.hit & (sel.slot == SLOT_W'(s));

    if (s == S_LINK) begin : g_keep
      always_ff @(posedge clk) begin
        if (rst)         words[s] <= DEF;
        else if (wr_hit) words[s] <= wdata & MASK;
      end
    end else begin : g_soft
      always_ff @(posedge clk) begin
        if (rst)           words[s] <= DEF;
        else if (wr_hit)   words[s] <= wdata & MASK;
        else if (soft_rst) words[s] <= DEF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= re;
      if (re) begin
        if (is_id)        rd_data <= ID_WORD;
        else if (sel.hit) rd_data <= words[sel.slot];
        else              rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/ccr_vol_map.sv
module ccr_vol_map
  import ccr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NSLOT-1:0][DATA_W-1:0] words,
  output logic [6:0]                   out_mst_l,
  output logic [6:0]                   out_mst_r,
  output logic [6:0]                   out_hp_l,
  output logic [6:0]                   out_hp_r,
  output logic [4:0]                   out_beep,
  output logic [5:0]                   out_phone,
  output logic [5:0]                   out_mic,
  output logic                         out_mic_boost,
  output logic [5:0]                   out_line_l,
  output logic [5:0]                   out_line_r,
  output logic [5:0]                   out_cd_l,
  output logic [5:0]                   out_cd_r,
  output logic [DATA_W-1:0]            out_link_cfg
);
  logic [NSLOT-1:0][DATA_W-1:0] src;

  always_comb begin
    for (int s = 0; s < NSLOT; s++)
      src[s] = rst ? slot_default(s) : words[s];
  end

  function automatic logic [6:0] fold6(logic m, logic [5:0] c);
    return m ? 7'h7F : {1'b0, c};
  endfunction
  function automatic logic [5:0] fold5(logic m, logic [4:0] c);
    return m ? 6'h3F : {1'b0, c};
  endfunction
  function automatic logic [4:0] fold4(logic m, logic [3:0] c);
    return m ? 5'h1F : {1'b0, c};
  endfunction

  always_ff @(posedge clk) begin
    out_mst_l     <= fold6(src[S_MST][MUTE_BIT], src[S_MST][13:8]);
    out_mst_r     <= fold6(src[S_MST][MUTE_BIT], src[S_MST][5:0]);
    out_hp_l      <= fold6(src[S_HP][MUTE_BIT], src[S_HP][13:8]);
    out_hp_r      <= fold6(src[S_HP][MUTE_BIT], src[S_HP][5:0]);
    out_beep      <= fold4(src[S_BEEP][MUTE_BIT], src[S_BEEP][4:1]);
    out_phone     <= fold5(src[S_PHONE][MUTE_BIT], src[S_PHONE][4:0]);
    out_mic       <= fold5(src[S_MIC][MUTE_BIT], src[S_MIC][4:0]);
    out_mic_boost <= src[S_MIC][BOOST_BIT];
    out_line_l    <= fold5(src[S_LINE][MUTE_BIT], src[S_LINE][12:8]);
    out_line_r    <= fold5(src[S_LINE][MUTE_BIT], src[S_LINE][4:0]);
    out_cd_l      <= fold5(src[S_CD][MUTE_BIT], src[S_CD][12:8]);
    out_cd_r      <= fold5(src[S_CD][MUTE_BIT], src[S_CD][4:0]);
    out_link_cfg  <= src[S_LINK];
  end
endmodule

// File: rtl/ccr_bank.sv
module ccr_bank
  import ccr_pkg::*;
#(
  parameter logic [9:0] CAP_ID   = 10'h040,
  parameter logic [4:0] ENH_CODE = 5'h0D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_re,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [6:0]        out_mst_l,
  output logic [6:0]        out_mst_r,
  output logic [6:0]        out_hp_l,
  output logic [6:0]        out_hp_r,
  output logic [4:0]        out_beep,
  output logic [5:0]        out_phone,
  output logic [5:0]        out_mic,
  output logic              out_mic_boost,
  output logic [5:0]        out_line_l,
  output logic [5:0]        out_line_r,
  output logic [5:0]        out_cd_l,
  output logic [5:0]        out_cd_r,
  output logic [DATA_W-1:0] out_link_cfg
);
  slot_sel_t                    sel;
  logic                         is_id;
  logic [NSLOT-1:0][DATA_W-1:0] words;

  ccr_decode u_dec (
    .idx   (host_idx),
    .sel   (sel),
    .is_id (is_id)
  );

  ccr_regfile #(.CAP_ID(CAP_ID), .ENH_CODE(ENH_CODE)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (host_we),
    .re       (host_re),
    .wdata    (host_wdata),
    .sel      (sel),
    .is_id    (is_id),
    .words    (words),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  ccr_vol_map u_map (
    .clk           (clk),
    .rst           (rst),
    .words         (words),
    .out_mst_l     (out_mst_l),
    .out_mst_r     (out_mst_r),
    .out_hp_l      (out_hp_l),
    .out_hp_r      (out_hp_r),
    .out_beep      (out_beep),
    .out_phone     (out_phone),
    .out_mic       (out_mic),
    .out_mic_boost (out_mic_boost),
    .out_line_l    (out_line_l),
    .out_line_r    (out_line_r),
    .out_cd_l      (out_cd_l),
    .out_cd_r      (out_cd_r),
    .out_link_cfg  (out_link_cfg)
  );
endmodule

// File: rtl/ccr_bank_chk.sv
module ccr_bank_chk #(
  parameter logic [9:0] CAP_ID   = 10'h040,
  parameter logic [4:0] ENH_CODE = 5'h0D
) (
  input logic        clk,
  input logic        rst,
  input logic [6:0]  host_idx,
  input logic        host_we,
  input logic        host_re,
  input logic [15:0] rd_data,
  input logic        rd_valid,
  input logic [6:0]  out_mst_l,
  input logic [5:0]  out_mic,
  input logic [5:0]  out_phone
);
  logic [5:0] pair;
  logic       unimpl;
  assign pair   = host_idx[6:1];
  assign unimpl = !(pair inside {6'h00, 6'h01, 6'h02, 6'h05, 6'h06,
                                 6'h07, 6'h08, 6'h09, 6'h3A});

  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    host_re |=> rd_valid);  // R10
  AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !host_re |=> !rd_valid);  // R10
  AST_ID_WORD: assert property (@(posedge clk) disable iff (rst)
    (host_re && pair == 6'h00) |=> rd_data == {1'b0, ENH_CODE, CAP_ID});  // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_re && unimpl) |=> rd_data == 16'h0000);  // R5
  AST_MST_MUTE_FORCE: assert property (@(posedge clk) disable iff (rst)
    out_mst_l[6] |-> out_mst_l[5:0] == 6'h3F);  // R7
  AST_MIC_MUTE_FORCE: assert property (@(posedge clk) disable iff (rst)
    out_mic[5] |-> out_mic[4:0] == 5'h1F);  // R7
  AST_SOFT_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (host_we && pair == 6'h00) ##1 !host_we |=> out_phone == 6'h3F);  // R2
endmodule

bind ccr_bank ccr_bank_chk #(.CAP_ID(CAP_ID), .ENH_CODE(ENH_CODE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .host_idx  (host_idx),
  .host_we   (host_we),
  .host_re   (host_re),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .out_mst_l (out_mst_l),
  .out_mic   (out_mic),
  .out_phone (out_phone)
);

// File: tb/ccr_bank_tb_top.sv
module ccr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  host_idx = '0;
  logic [15:0] host_wdata = '0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [6:0]  out_mst_l, out_mst_r, out_hp_l, out_hp_r;
  logic [4:0]  out_beep;
  logic [5:0]  out_phone, out_mic, out_line_l, out_line_r, out_cd_l, out_cd_r;
  logic        out_mic_boost;
  logic [15:0] out_link_cfg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ccr_bank dut_i (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop the expected word for every returned read
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid && !rst) begin
        if (exp_q.size() == 0) chk("R10 unexpected rd_valid", 16'h1, 16'h0);
        else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic rd(logic [6:0] idx, logic [15:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_idx = idx;
    host_re  = 1'b1;
    @(negedge clk);
    host_re  = 1'b0;
  endtask

  task automatic wr(logic [6:0] idx, logic [15:0] data);
    @(negedge clk);
    host_idx   = idx;
    host_wdata = data;
    host_we    = 1'b1;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 beep audible in reset", {11'd0, out_beep}, 16'h0000);
    chk("R9 master muted in reset", {9'd0, out_mst_l}, 16'h007F);
    rst = 1'b0;
    rd(7'h00, 16'h3440, "R3 id word");
    rd(7'h02, 16'h8000, "R1 master default");
    rd(7'h04, 16'h8000, "R1 headphone default");
    rd(7'h0A, 16'h0000, "R1 beep default");
    rd(7'h0C, 16'h8008, "R1 phone default");
    rd(7'h0E, 16'h8008, "R1 mic default");
    rd(7'h10, 16'h8808, "R1 line default");
    rd(7'h12, 16'h8808, "R1 cd default");
    rd(7'h74, 16'h0000, "R1 link default");
    rd(7'h06, 16'h0000, "R5 unimplemented read");

    wr(7'h02, 16'h2A15); settle();
    rd(7'h03, 16'h2A15, "R4 odd alias read");
    chk("R7 master left code", {9'd0, out_mst_l}, 16'h002A);
    chk("R7 master right code", {9'd0, out_mst_r}, 16'h0015);

    wr(7'h02, 16'hFFFF); settle();
    rd(7'h02, 16'hBF3F, "R6 master mask");
    chk("R7 mute forces max", {9'd0, out_mst_r}, 16'h007F);

    wr(7'h0F, 16'h0045); settle();
    rd(7'h0E, 16'h0045, "R4 odd alias write");
    chk("R8 mic boost", {15'd0, out_mic_boost}, 16'h0001);
    chk("R7 mic code", {10'd0, out_mic}, 16'h0005);

    wr(7'h10, 16'hFF03); settle();
    rd(7'h10, 16'h9F03, "R6 line mask");
    chk("R7 line left muted", {10'd0, out_line_l}, 16'h003F);
    wr(7'h12, 16'h1F03); settle();
    chk("R7 cd left code", {10'd0, out_cd_l}, 16'h001F);
    chk("R7 cd right code", {10'd0, out_cd_r}, 16'h0003);

    wr(7'h0A, 16'h7FFE); settle();
    rd(7'h0A, 16'h001E, "R6 beep mask");
    chk("R7 beep level", {11'd0, out_beep}, 16'h000F);

    wr(7'h74, 16'hA5C3);
    wr(7'h06, 16'h1234);
    rd(7'h06, 16'h0000, "R5 write ignored read zero");
    rd(7'h02, 16'hBF3F, "R5 neighbour unchanged");

    wr(7'h01, 16'h0000); settle();
    rd(7'h02, 16'h8000, "R2 soft reset master");
    rd(7'h0E, 16'h8008, "R2 soft reset mic");
    rd(7'h12, 16'h8808, "R2 soft reset cd");
    rd(7'h74, 16'hA5C3, "R2 link kept");
    chk("R2 link output kept", out_link_cfg, 16'hA5C3);
    chk("R2 boost cleared", {15'd0, out_mic_boost}, 16'h0000);

    @(negedge clk);
    exp_q.push_back(16'h8008);
    tag_q.push_back("R10 same-cycle write not visible");
    host_idx = 7'h0C; host_wdata = 16'h0005; host_we = 1'b1; host_re = 1'b1;
    @(negedge clk);
    host_we = 1'b0; host_re = 1'b0;
    rd(7'h0C, 16'h0005, "R10 write visible next read");
    settle();
    chk("R7 phone code", {10'd0, out_phone}, 16'h0005);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 beep in second reset", {11'd0, out_beep}, 16'h0000);
    rst = 1'b0;
    rd(7'h74, 16'h0000, "R1 hard reset clears link");
    rd(7'h0C, 16'h8008, "R1 hard reset phone");
    repeat (3) @(negedge clk);
    chk("R10 all reads returned", 16'(exp_q.size()), 16'h0000);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule